// File: doc/BRIEF.md
# Trap Entry Unit

This block holds the current privilege level and the state a core keeps about taken traps: the supervisor and machine vector bases, exception PCs, causes, faulting addresses, the interrupt-enable stack bits and the debug-entry record. When the pipeline raises a trap strobe with a cause, a faulting PC and an optional faulting address, the unit chooses one of four routes and updates its registers on the same clock edge. It presents the redirect PC and the new privilege one cycle later. The four routes are: handle at supervisor level, handle at machine level, enter debug mode on a breakpoint, or stay in debug mode.

Delegation to supervisor level is chosen per cause index. Interrupts use one mask and exceptions use another. Machine-level dispatch can be vectored, but only interrupts are vectored. A breakpoint can be diverted into debug mode through one enable bit per privilege. While the core reports that it is already in debug mode, traps only pick one of two fixed debug addresses. A single configuration write port loads the vector bases, the two delegation masks, the enable bits, the breakpoint enables and the privilege level.

Top module: `trap_unit`

## Requirements
- R1: After a synchronous active-low reset: privilege is machine (3), every status bit is 0, all vectors, masks, saved PCs, causes and addresses are 0, `redir_vld` is 0 and `redir_pc` equals `RESET_VEC`.
- R2: A non-debug trap goes to supervisor only if the privilege is user (0) or supervisor (1), the cause index is below XLEN, and the selected mask bit at that index is set. Otherwise it goes to machine. In particular, no trap taken at machine privilege leaves machine privilege.
- R3: Interrupts (`trap_irq`=1) select the interrupt delegation mask. Exceptions select the exception delegation mask.
- R4: Supervisor entry does the following. `spie` takes `sie`, `spp` takes privilege bit 0, and `sie` is cleared. `sepc` takes `trap_pc` and `scause` takes {irq in bit XLEN-1, zero-extended code}. Privilege becomes 1 and the redirect is the supervisor vector. Status layout: [0] sie, [1] mie, [2] spie, [3] mpie, [4] spp, [6:5] mpp.
- R5: Machine entry does the following. `mpie` takes `mie`, `mpp` takes the privilege, and `mie` is cleared. `mepc` and `mcause` are written in the same way as for supervisor entry, and privilege becomes 3.
- R6: If machine vector bit 0 is set and the trap is an interrupt, the machine redirect is (vector with bit 0 cleared) + 4 × code. Otherwise it is the vector with bit 0 cleared.
- R7: `sbad`/`mbad` are written only when `bad_vld` is 1. The saved PC is always written.
- R8: An exception with code 3 (breakpoint), taken outside debug mode while the breakpoint-enable bit for the current privilege is set, enters debug mode. Enable bits: [0] user, [1] supervisor, [2] privilege 2, [3] machine. On entry `dbg_why`=1, `dbg_prv` takes the privilege, `dpc` takes `trap_pc`, privilege becomes 3 and the redirect is `DBG_ENTRY`. The normal trap state is left unchanged.
- R9: With `dbg_mode`=1, a breakpoint redirects to `DBG_ENTRY` and any other trap redirects to `DBG_TVEC`. No other state changes.
- R10: Configuration selects are 0 supervisor vector, 1 machine vector, 2 exception mask, 3 interrupt mask, 4 enables ({mie,sie} from bits [1:0]), 5 breakpoint enables (bits [3:0]), 6 privilege (bits [1:0]); select 7 does nothing. A supervisor vector write clears bits [1:0]. A machine vector write clears bit 1 only.
- R11: A privilege write of 2 stores user (0).
- R12: `redir_vld` is high for exactly the one cycle after each cycle with `trap_vld`. `redir_pc` is updated together with it and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_vld | input | 1 | Trap strobe |
| trap_irq | input | 1 | Trap is an interrupt |
| trap_code | input | CODE_W | Cause index |
| trap_pc | input | XLEN | PC of the trapping instruction |
| bad_vld | input | 1 | `bad_addr` is meaningful |
| bad_addr | input | XLEN | Faulting address |
| dbg_mode | input | 1 | Core is currently in debug mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target select |
| cfg_wdata | input | XLEN | Configuration write data |
| redir_vld | output | 1 | Redirect strobe |
| redir_pc | output | XLEN | Redirect target |
| cur_priv | output | 2 | Current privilege |
| status | output | 7 | Enable stack bits |
| stvec_o | output | XLEN | Supervisor vector base |
| mtvec_o | output | XLEN | Machine vector base |
| sepc | output | XLEN | Supervisor saved PC |
| scause | output | XLEN | Supervisor cause |
| sbad | output | XLEN | Supervisor faulting address |
| mepc | output | XLEN | Machine saved PC |
| mcause | output | XLEN | Machine cause |
| mbad | output | XLEN | Machine faulting address |
| dpc | output | XLEN | Debug saved PC |
| dbg_why | output | 3 | Debug entry reason |
| dbg_prv | output | 2 | Privilege at debug entry |

## Verification
The assertions assume that `cfg_we` and `trap_vld` are never high in the same cycle. The trap has priority in the RTL, but the hold and clearing properties are only stated for trap-only cycles. The stimulus keeps to this assumption: the random phase only raises a configuration write in cycles where it left the trap strobe low. The properties also assume that `trap_code` fits the index range of the mask width, which the default `CODE_W` of 6 against an XLEN of 32 provides. Codes above XLEN-1 are still driven, to check that they are never delegated.

// File: rtl/trap_pkg.sv
// Shared encodings for the trap entry unit.
// Assumes privilege is a 2-bit field where 3 is the most privileged.
package trap_pkg;
    localparam logic [1:0] LVL_USER  = 2'd0;
    localparam logic [1:0] LVL_SUPER = 2'd1;
    localparam logic [1:0] LVL_RSVD  = 2'd2;
    localparam logic [1:0] LVL_MACH  = 2'd3;

    localparam int unsigned BRK_CODE   = 3;
    localparam logic [2:0]  WHY_SWBRK  = 3'd1;

    localparam logic [2:0] SEL_STVEC  = 3'd0;
    localparam logic [2:0] SEL_MTVEC  = 3'd1;
    localparam logic [2:0] SEL_EDELEG = 3'd2;
    localparam logic [2:0] SEL_IDELEG = 3'd3;
    localparam logic [2:0] SEL_IE     = 3'd4;
    localparam logic [2:0] SEL_BRKEN  = 3'd5;
    localparam logic [2:0] SEL_PRIV   = 3'd6;

    typedef enum logic [1:0] {
        RT_MACH      = 2'd0,
        RT_SUPER     = 2'd1,
        RT_DBG_ENTER = 2'd2,
        RT_DBG_STAY  = 2'd3
    } route_e;
endpackage

// File: rtl/trap_route.sv
// Chooses where a trap is handled: supervisor, machine, debug entry or
// debug stay. Purely combinational. Assumes CODE_W >= log2(XLEN).
module trap_route
    import trap_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 6
) (
    input  logic              irq,
    input  logic [CODE_W-1:0] code,
    input  logic [1:0]        priv,
    input  logic              dbg_mode,
    input  logic [XLEN-1:0]   edeleg,
    input  logic [XLEN-1:0]   ideleg,
    input  logic [3:0]        brk_en,
    output logic              brk,
    output route_e            route
);
    localparam int IDX_W = $clog2(XLEN);

    logic [XLEN-1:0] mask;
    logic            in_range;
    logic            deleg_hit;

    // Select the mask by trap kind and look up the delegation bit.
    always_comb begin
        brk       = !irq && (code == CODE_W'(BRK_CODE));
        mask      = irq ? ideleg : edeleg;
        in_range  = (32'(code) < XLEN);
        deleg_hit = in_range && mask[code[IDX_W-1:0]] && (priv <= LVL_SUPER);
    end

    // Pick the route in priority order: debug stay, debug entry, delegation.
    always_comb begin
        if (dbg_mode)               route = RT_DBG_STAY;
        else if (brk && brk_en[priv]) route = RT_DBG_ENTER;
        else if (deleg_hit)         route = RT_SUPER;
        else                        route = RT_MACH;
    end
endmodule

// File: rtl/trap_target.sv
// Computes the redirect PC for a chosen route. Combinational.
// Assumes the vector registers already carry their write masking.
module trap_target
    import trap_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              CODE_W    = 6,
    parameter logic [XLEN-1:0] DBG_ENTRY = '0,
    parameter logic [XLEN-1:0] DBG_TVEC  = '0
) (
    input  route_e            route,
    input  logic              irq,
    input  logic              brk,
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   stvec,
    input  logic [XLEN-1:0]   mtvec,
    output logic [XLEN-1:0]   target
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offs;

    // Machine base without the mode bit, plus the vectored offset for interrupts.
    always_comb begin
        base = {mtvec[XLEN-1:1], 1'b0};
        offs = (mtvec[0] && irq) ? ({{(XLEN-CODE_W){1'b0}}, code} << 2) : '0;
    end

    // Select the target address for the route.
    always_comb begin
        unique case (route)
            RT_SUPER:     target = stvec;
            RT_DBG_ENTER: target = DBG_ENTRY;
            RT_DBG_STAY:  target = brk ? DBG_ENTRY : DBG_TVEC;
            default:      target = base + offs;
        endcase
    end
endmodule

// File: rtl/trap_unit.sv
// Trap entry unit: holds privilege, enable stack, vectors, delegation masks
// and saved trap state; updates them on a trap strobe and issues a
// registered redirect one cycle later. Assumes cfg_we and trap_vld are not
// raised together; if they are, the trap wins and the write is dropped.
module trap_unit
    import trap_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              CODE_W    = 6,
    parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000,
    parameter logic [XLEN-1:0] DBG_ENTRY = 32'h0000_0800,
    parameter logic [XLEN-1:0] DBG_TVEC  = 32'h0000_0808
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_vld,
    input  logic              trap_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic              bad_vld,
    input  logic [XLEN-1:0]   bad_addr,
    input  logic              dbg_mode,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [XLEN-1:0]   cfg_wdata,
    output logic              redir_vld,
    output logic [XLEN-1:0]   redir_pc,
    output logic [1:0]        cur_priv,
    output logic [6:0]        status,
    output logic [XLEN-1:0]   stvec_o,
    output logic [XLEN-1:0]   mtvec_o,
    output logic [XLEN-1:0]   sepc,
    output logic [XLEN-1:0]   scause,
    output logic [XLEN-1:0]   sbad,
    output logic [XLEN-1:0]   mepc,
    output logic [XLEN-1:0]   mcause,
    output logic [XLEN-1:0]   mbad,
    output logic [XLEN-1:0]   dpc,
    output logic [2:0]        dbg_why,
    output logic [1:0]        dbg_prv
);
    localparam int PAD_W = XLEN - 1 - CODE_W;

    logic            sie, mie, spie, mpie, spp;
    logic [1:0]      mpp;
    logic [XLEN-1:0] edeleg, ideleg;
    logic [3:0]      brk_en;
    logic            brk;
    route_e          route;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] cause_w;

    trap_route #(.XLEN(XLEN), .CODE_W(CODE_W)) u_route (
        .irq      (trap_irq),
        .code     (trap_code),
        .priv     (cur_priv),
        .dbg_mode (dbg_mode),
        .edeleg   (edeleg),
        .ideleg   (ideleg),
        .brk_en   (brk_en),
        .brk      (brk),
        .route    (route)
    );

    trap_target #(.XLEN(XLEN), .CODE_W(CODE_W),
                  .DBG_ENTRY(DBG_ENTRY), .DBG_TVEC(DBG_TVEC)) u_target (
        .route  (route),
        .irq    (trap_irq),
        .brk    (brk),
        .code   (trap_code),
        .stvec  (stvec_o),
        .mtvec  (mtvec_o),
        .target (target)
    );

    // Cause word: interrupt flag in the top bit, code zero-extended below it.
    always_comb cause_w = {trap_irq, {PAD_W{1'b0}}, trap_code};

    // Pack the enable stack for the status output.
    always_comb status = {mpp, spp, mpie, spie, mie, sie};

    // Registered redirect strobe and target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_vld <= 1'b0;
            redir_pc  <= RESET_VEC;
        end else begin
            redir_vld <= trap_vld;
            if (trap_vld) redir_pc <= target;
        end
    end

    // Trap state update, with configuration writes in trap-free cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_priv <= LVL_MACH;
            {sie, mie, spie, mpie, spp} <= '0;
            mpp     <= LVL_USER;
            stvec_o <= '0;  mtvec_o <= '0;
            edeleg  <= '0;  ideleg  <= '0;  brk_en <= '0;
            sepc    <= '0;  scause  <= '0;  sbad   <= '0;
            mepc    <= '0;  mcause  <= '0;  mbad   <= '0;
            dpc     <= '0;  dbg_why <= '0;  dbg_prv <= LVL_USER;
        end else if (trap_vld) begin
            unique case (route)
                RT_SUPER: begin
                    spie     <= sie;
                    spp      <= cur_priv[0];
                    sie      <= 1'b0;
                    sepc     <= trap_pc;
                    scause   <= cause_w;
                    if (bad_vld) sbad <= bad_addr;
                    cur_priv <= LVL_SUPER;
                end
                RT_MACH: begin
                    mpie     <= mie;
                    mpp      <= cur_priv;
                    mie      <= 1'b0;
                    mepc     <= trap_pc;
                    mcause   <= cause_w;
                    if (bad_vld) mbad <= bad_addr;
                    cur_priv <= LVL_MACH;
                end
                RT_DBG_ENTER: begin
                    dbg_why  <= WHY_SWBRK;
                    dbg_prv  <= cur_priv;
                    dpc      <= trap_pc;
                    cur_priv <= LVL_MACH;
                end
                default: ;
            endcase
        end else if (cfg_we) begin
            unique case (cfg_sel)
                SEL_STVEC:  stvec_o <= {cfg_wdata[XLEN-1:2], 2'b00};
                SEL_MTVEC:  mtvec_o <= {cfg_wdata[XLEN-1:2], 1'b0, cfg_wdata[0]};
                SEL_EDELEG: edeleg  <= cfg_wdata;
                SEL_IDELEG: ideleg  <= cfg_wdata;
                SEL_IE:     {mie, sie} <= cfg_wdata[1:0];
                SEL_BRKEN:  brk_en  <= cfg_wdata[3:0];
                SEL_PRIV:   cur_priv <= (cfg_wdata[1:0] == LVL_RSVD) ? LVL_USER
                                                                      : cfg_wdata[1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/trap_unit_chk.sv
// Property checker for the trap entry unit, bound to every trap_unit.
// Assumes cfg_we is never raised in a trap cycle.
module trap_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_vld,
    input logic            dbg_mode,
    input logic            redir_vld,
    input logic [1:0]      cur_priv,
    input logic [6:0]      status,
    input logic [XLEN-1:0] stvec_o,
    input logic [XLEN-1:0] mtvec_o,
    input logic [XLEN-1:0] sepc,
    input logic [XLEN-1:0] mepc
);
    p_redir_after_trap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        trap_vld |=> redir_vld);

    p_redir_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_vld |=> !redir_vld);

    p_mach_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_vld && !dbg_mode && cur_priv == 2'd3) |=> cur_priv == 2'd3);

    p_sup_clears_sie_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_vld && !dbg_mode && cur_priv != 2'd3) |=>
            (cur_priv == 2'd1) ? (status[0] == 1'b0) : 1'b1);

    p_debug_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_vld && dbg_mode) |=>
            ($stable(cur_priv) && $stable(status) && $stable(sepc) && $stable(mepc)));

    p_stvec_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stvec_o[1:0] == 2'b00);

    p_mtvec_bit1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mtvec_o[1] == 1'b0);

    p_no_rsvd_priv_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cur_priv != 2'd2);
endmodule

bind trap_unit trap_unit_chk #(.XLEN(XLEN)) i_trap_unit_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trap_vld  (trap_vld),
    .dbg_mode  (dbg_mode),
    .redir_vld (redir_vld),
    .cur_priv  (cur_priv),
    .status    (status),
    .stvec_o   (stvec_o),
    .mtvec_o   (mtvec_o),
    .sepc      (sepc),
    .mepc      (mepc)
);

// File: tb/test_trap_unit.sv
`timescale 1ns/1ps
// Bench for trap_unit: behavioural reference model compared every cycle,
// plus directed checks with hand-computed values.
module test_trap_unit;
    localparam logic [31:0] RV = 32'h0000_1000;
    localparam logic [31:0] DE = 32'h0000_0800;
    localparam logic [31:0] DT = 32'h0000_0808;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        trap_vld = 0, trap_irq = 0, bad_vld = 0, dbg_mode = 0, cfg_we = 0;
    logic [5:0]  trap_code = 0;
    logic [31:0] trap_pc = 0, bad_addr = 0, cfg_wdata = 0;
    logic [2:0]  cfg_sel = 0;
    logic        redir_vld;
    logic [31:0] redir_pc, stvec_o, mtvec_o, sepc, scause, sbad, mepc, mcause, mbad, dpc;
    logic [1:0]  cur_priv, dbg_prv;
    logic [6:0]  status;
    logic [2:0]  dbg_why;

    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    trap_unit i_trap_unit (.*);

    // Reference model state.
    int          m_priv, m_why, m_dprv;
    bit          m_sie, m_mie, m_spie, m_mpie, m_spp, m_rv;
    int          m_mpp;
    logic [31:0] m_stvec, m_mtvec, m_ed, m_id, m_sepc, m_scause, m_sbad;
    logic [31:0] m_mepc, m_mcause, m_mbad, m_dpc, m_rpc, msk;
    logic [3:0]  m_brk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_priv = 3; m_sie = 0; m_mie = 0; m_spie = 0; m_mpie = 0; m_spp = 0; m_mpp = 0;
            m_stvec = 0; m_mtvec = 0; m_ed = 0; m_id = 0; m_brk = 0;
            m_sepc = 0; m_scause = 0; m_sbad = 0; m_mepc = 0; m_mcause = 0; m_mbad = 0;
            m_dpc = 0; m_why = 0; m_dprv = 0; m_rv = 0; m_rpc = RV;
        end else begin
            m_rv = trap_vld;
            if (trap_vld) begin
                if (dbg_mode) begin
                    m_rpc = (!trap_irq && trap_code == 3) ? DE : DT;
                end else if (!trap_irq && trap_code == 3 && m_brk[m_priv]) begin
                    m_why = 1; m_dprv = m_priv; m_dpc = trap_pc; m_priv = 3; m_rpc = DE;
                end else begin
                    msk = trap_irq ? m_id : m_ed;
                    if (m_priv <= 1 && trap_code < 32 && msk[trap_code % 32]) begin
                        m_spie = m_sie; m_spp = m_priv[0]; m_sie = 0;
                        m_sepc = trap_pc; m_scause = {trap_irq, 25'd0, trap_code};
                        if (bad_vld) m_sbad = bad_addr;
                        m_priv = 1; m_rpc = m_stvec;
                    end else begin
                        m_mpie = m_mie; m_mpp = m_priv; m_mie = 0;
                        m_mepc = trap_pc; m_mcause = {trap_irq, 25'd0, trap_code};
                        if (bad_vld) m_mbad = bad_addr;
                        m_priv = 3;
                        m_rpc = (m_mtvec & ~32'd1) + ((m_mtvec[0] && trap_irq) ? trap_code * 4 : 0);
                    end
                end
            end else if (cfg_we) begin
                case (cfg_sel)
                    0: m_stvec = cfg_wdata & ~32'd3;
                    1: m_mtvec = cfg_wdata & ~32'd2;
                    2: m_ed = cfg_wdata;
                    3: m_id = cfg_wdata;
                    4: begin m_sie = cfg_wdata[0]; m_mie = cfg_wdata[1]; end
                    5: m_brk = cfg_wdata[3:0];
                    6: m_priv = (cfg_wdata[1:0] == 2) ? 0 : cfg_wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        chk("R12 redir_vld", 32'(redir_vld), 32'(m_rv));
        chk("R12 redir_pc", redir_pc, m_rpc);
        chk("R5 cur_priv", 32'(cur_priv), m_priv);
        chk("R4 status", 32'(status),
            {25'd0, m_mpp[1:0], m_spp, m_mpie, m_spie, m_mie, m_sie});
        chk("R10 stvec", stvec_o, m_stvec);
        chk("R10 mtvec", mtvec_o, m_mtvec);
        chk("R4 sepc", sepc, m_sepc);
        chk("R4 scause", scause, m_scause);
        chk("R7 sbad", sbad, m_sbad);
        chk("R5 mepc", mepc, m_mepc);
        chk("R5 mcause", mcause, m_mcause);
        chk("R7 mbad", mbad, m_mbad);
        chk("R8 dpc", dpc, m_dpc);
        chk("R8 dbg_why", 32'(dbg_why), m_why);
        chk("R8 dbg_prv", 32'(dbg_prv), m_dprv);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_model();
    endtask

    task automatic cfg(input logic [2:0] s, input logic [31:0] d);
        cfg_we = 1; cfg_sel = s; cfg_wdata = d;
        tick();
        cfg_we = 0;
    endtask

    task automatic trap(input bit irq, input int code, input logic [31:0] pc,
                        input bit bv, input logic [31:0] ba, input bit dm);
        trap_vld = 1; trap_irq = irq; trap_code = 6'(code); trap_pc = pc;
        bad_vld = bv; bad_addr = ba; dbg_mode = dm;
        tick();
        trap_vld = 0; bad_vld = 0; dbg_mode = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare_model();
        chk("R1 reset pc", redir_pc, RV);
        chk("R1 reset priv", 32'(cur_priv), 3);
        chk("R1 reset status", 32'(status), 0);
        chk("R1 reset vld", 32'(redir_vld), 0);

        cfg(0, 32'h1000_0007);  chk("R10 stvec mask", stvec_o, 32'h1000_0004);
        cfg(1, 32'h2000_0003);  chk("R10 mtvec mask", mtvec_o, 32'h2000_0001);
        cfg(7, 32'hFFFF_FFFF);  chk("R10 sel7 no effect", mtvec_o, 32'h2000_0001);
        cfg(4, 3);              chk("R10 enables", 32'(status), 3);

        trap(0, 2, 32'h400, 1, 32'hBAD0, 0);
        chk("R6 exception not vectored", redir_pc, 32'h2000_0000);
        chk("R5 mepc", mepc, 32'h400);
        chk("R5 stack", 32'(status), 32'h69);
        chk("R7 mbad written", mbad, 32'hBAD0);
        tick();
        chk("R12 pulse ends", 32'(redir_vld), 0);

        trap(1, 7, 32'h404, 0, 32'h1111, 0);
        chk("R6 vectored irq", redir_pc, 32'h2000_001C);
        chk("R5 irq cause", mcause, 32'h8000_0007);
        chk("R7 mbad kept", mbad, 32'hBAD0);

        cfg(2, 32'h4); cfg(3, 32'h20); cfg(6, 1); cfg(4, 3);
        trap(0, 2, 32'h500, 0, 32'h2222, 0);
        chk("R4 sup redirect", redir_pc, 32'h1000_0004);
        chk("R4 sup stack", 32'(status), 32'h76);
        chk("R4 sup priv", 32'(cur_priv), 1);
        chk("R7 sbad kept", sbad, 0);

        trap(1, 2, 32'h504, 1, 32'hCAFE, 0);
        chk("R3 irq uses irq mask", 32'(cur_priv), 3);
        chk("R6 vectored code 2", redir_pc, 32'h2000_0008);

        cfg(6, 1);
        trap(1, 5, 32'h508, 0, 0, 0);
        chk("R3 irq delegated", 32'(cur_priv), 1);
        chk("R3 sup cause", scause, 32'h8000_0005);

        cfg(6, 2);              chk("R11 reserved to user", 32'(cur_priv), 0);
        cfg(2, 32'hFFFF_FFFF);
        trap(0, 40, 32'h600, 0, 0, 0);
        chk("R2 code beyond XLEN", 32'(cur_priv), 3);
        chk("R2 mcause", mcause, 32'd40);

        cfg(5, 1); cfg(6, 0);
        trap(0, 3, 32'h700, 0, 0, 0);
        chk("R8 debug redirect", redir_pc, DE);
        chk("R8 dpc", dpc, 32'h700);
        chk("R8 why", 32'(dbg_why), 1);
        chk("R8 prv", 32'(dbg_prv), 0);
        chk("R8 mepc untouched", mepc, 32'h600);

        trap(0, 3, 32'h704, 0, 0, 0);
        chk("R8 disabled at machine", redir_pc, 32'h2000_0000);

        trap(0, 3, 32'h708, 0, 0, 1);
        chk("R9 debug breakpoint", redir_pc, DE);
        trap(0, 2, 32'h70C, 0, 0, 1);
        chk("R9 debug other", redir_pc, DT);
        chk("R9 no state change", mepc, 32'h704);

        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(1) == 1) begin
                trap_vld = 1; trap_irq = 1'($urandom_range(1));
                trap_code = 6'($urandom_range(63));
                if ($urandom_range(3) == 0) trap_code = 6'd3;
                trap_pc = $urandom; bad_vld = 1'($urandom_range(1)); bad_addr = $urandom;
                dbg_mode = ($urandom_range(7) == 0);
            end else if ($urandom_range(1) == 1) begin
                cfg_we = 1; cfg_sel = 3'($urandom_range(7)); cfg_wdata = $urandom;
            end
            tick();
            trap_vld = 0; cfg_we = 0; dbg_mode = 0; bad_vld = 0;
        end

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog R12 actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule